// File: doc/BRIEF.md
# Dual-Mode Interrupt Delivery Unit

This unit receives vector requests from an address-translation engine and turns each one into an outgoing notification. A single control bit sets the kind. With the bit set, the request pulses one of four wired interrupt lines for one clock. The integration connects these lines to consecutive inputs of an interrupt controller, starting from a base chosen at build time. With the bit clear, the unit reads a small message table and issues a 32-bit memory write. The address of that write comes from the table entry and so does its data.

Software programs the table through a 32-bit word register port. In the same window it reads a pending-bit array that shows message requests still waiting to be issued. Only one message write is outstanding at a time. Requests that arrive while a write is in flight wait in a per-vector pending register, and the lowest vector is served first. A request whose vector is out of range for the current mode is dropped and sets a sticky error flag.

Top module: `intr_deliver`

## Requirements
- R1: After reset every table word, the control register, the status register and both pending-array words read 0, `memValid` is low and `wiredIrq` is 0.
- R2: When control bit 0 (offset 0x000) is 1, a request with vector v < 4 drives `wiredIrq` to the one-hot value 1<<v for exactly one cycle, the cycle after the request is sampled, and issues no message write.
- R3: When control bit 0 is 0, a request with vector v < 5 leads to a write on the memory port. `memAddr` is {table word 4v+1, table word 4v} and `memData` is table word 4v+2. Bits [7:0] of `memData` form the byte at the lowest address (little-endian). `memValid` stays high with `memAddr` and `memData` stable until a cycle with `memReady` high.
- R4: At most one message write is outstanding. Requests that arrive meanwhile are held per vector and issued lowest vector first.
- R5: The pending-bit array is at offset 0x400 (bit v of word 0x400 is the pending flag of vector v) and 0x404 (always 0). It is 64 bits wide. Writes to it have no effect.
- R6: Table word w of entry e is at offset 0x300 + 16e + 4w, for e 0..4 and w 0..3. Each word is readable and writable. A 64-bit address field is accessed as two word accesses: the low word at the lower offset, the high word 4 bytes above it.
- R7: A request with vector >= 4 in wired mode, or >= 5 in message mode, produces no pulse and no write. It sets status bit 0 (offset 0x004), which stays set until software writes 1 to that bit.
- R8: Control bit 0 at offset 0x000 is readable and writable and selects the mode seen by each request in the cycle it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Vector request strobe, one request per cycle |
| reqVector | input | 3 | Requested vector index |
| regWrEn | input | 1 | Register word write strobe |
| regAddr | input | 12 | Register byte offset (word aligned) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| wiredIrq | output | 4 | Wired interrupt lines, one-cycle pulses |
| memValid | output | 1 | Message write request valid |
| memReady | input | 1 | Message write accepted |
| memAddr | output | 64 | Message write byte address |
| memData | output | 32 | Message write data, little-endian |

## Verification
On every cycle the assertions check the following. At most one wired line is high, and a pulse always follows a request. A pending message write holds its address and data until accepted. An out-of-range vector never pulses a line. The error flag stays set until software clears it. The bench scenarios show the values themselves: the table contents, the pending-array layout, and the lowest-first order of queued writes. They also show that pending-array writes are ignored and that each mode routes exactly the in-range vectors.

// File: rtl/intr_pkg.sv
package intr_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic issue;   // load a message write from the table
    logic setErr;  // out-of-range request seen
  } ctrlStrobes_t;
endpackage

// File: rtl/intr_regs.sv
module intr_regs #(
  parameter int NumVec = 5,
  parameter int ReqW   = 3,
  parameter int AddrW  = 12,
  parameter logic [AddrW-1:0] MsgBase = 12'h300
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [AddrW-1:0]           regAddr,
  input  logic [31:0]                regWrData,
  output logic [31:0]                regRdData,
  input  intr_pkg::ctrlStrobes_t     strobes,
  input  logic [ReqW-1:0]            issueVec,
  input  logic [NumVec-1:0]          pendBits,
  output logic                       wiredMode,
  output logic                       errFlag,
  output logic [63:0]                memAddr,
  output logic [31:0]                memData
);
  localparam int NumWords = NumVec * 4;
  localparam int IdxW     = $clog2(NumWords);
  localparam int PbaWords = ((NumVec + 63) / 64) * 2;
  localparam int PbaIdxW  = (PbaWords > 1) ? $clog2(PbaWords) : 1;
  localparam logic [AddrW-1:0] CtrlOff  = '0;
  localparam logic [AddrW-1:0] StatOff  = AddrW'(4);
  localparam logic [AddrW-1:0] TblBytes = AddrW'(NumWords * 4);
  localparam logic [AddrW-1:0] PbaOff   = MsgBase + AddrW'(256);
  localparam logic [AddrW-1:0] PbaBytes = AddrW'(PbaWords * 4);

  logic [31:0] tbl [NumWords];
  logic [AddrW-1:0] tblRel, pbaRel;
  logic tblHit, pbaHit;
  logic [IdxW-1:0] tblIdx, issueBase;
  logic [PbaIdxW-1:0] pbaIdx;
  logic [PbaWords*32-1:0] pendPad;

  assign tblRel    = regAddr - MsgBase;
  assign pbaRel    = regAddr - PbaOff;
  assign tblHit    = tblRel < TblBytes;
  assign pbaHit    = pbaRel < PbaBytes;
  assign tblIdx    = tblRel[IdxW+1:2];
  assign pbaIdx    = pbaRel[PbaIdxW+1:2];
  assign pendPad   = {{(PbaWords*32-NumVec){1'b0}}, pendBits};
  assign issueBase = IdxW'(issueVec) << 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NumWords; w++) tbl[w] <= '0;
    end else if (regWrEn && tblHit) begin
      tbl[tblIdx] <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiredMode <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (regWrEn && regAddr == CtrlOff) wiredMode <= regWrData[0];
      if (strobes.setErr) errFlag <= 1'b1;
      else if (regWrEn && regAddr == StatOff && regWrData[0]) errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memData <= '0;
    end else if (strobes.issue) begin
      memAddr <= {tbl[issueBase + IdxW'(1)], tbl[issueBase]};
      memData <= tbl[issueBase + IdxW'(2)];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CtrlOff)      regRdData[0] = wiredMode;
    else if (regAddr == StatOff) regRdData[0] = errFlag;
    else if (tblHit)             regRdData = tbl[tblIdx];
    else if (pbaHit)             regRdData = pendPad[32*int'(pbaIdx) +: 32];
  end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl #(
  parameter int NumVec   = 5,
  parameter int NumWired = 4,
  parameter int ReqW     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ReqW-1:0]        reqVector,
  input  logic                   wiredMode,
  input  logic                   memReady,
  output logic                   memValid,
  output logic [NumWired-1:0]    wiredIrq,
  output logic [NumVec-1:0]      pendBits,
  output intr_pkg::ctrlStrobes_t strobes,
  output logic [ReqW-1:0]        issueVec
);
  localparam logic [ReqW-1:0] WiredLim = ReqW'(NumWired);
  localparam logic [ReqW-1:0] MsgLim   = ReqW'(NumVec);

  logic busy, inRange, msgReq, wiredReq;
  logic [NumVec-1:0] pend, setMask, clrMask;

  assign inRange  = wiredMode ? (reqVector < WiredLim) : (reqVector < MsgLim);
  assign msgReq   = reqValid && !wiredMode && inRange;
  assign wiredReq = reqValid && wiredMode && inRange;
  assign setMask  = msgReq ? (NumVec'(1) << reqVector) : '0;

  always_comb begin
    issueVec = '0;
    for (int i = NumVec - 1; i >= 0; i--) begin
      if (pend[i]) issueVec = ReqW'(i);
    end
  end

  assign strobes.issue  = !busy && (|pend);
  assign strobes.setErr = reqValid && !inRange;
  assign clrMask        = strobes.issue ? (NumVec'(1) << issueVec) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      busy     <= 1'b0;
      wiredIrq <= '0;
    end else begin
      pend     <= (pend & ~clrMask) | setMask;
      wiredIrq <= wiredReq ? (NumWired'(1) << reqVector) : '0;
      if (strobes.issue) busy <= 1'b1;
      else if (busy && memReady) busy <= 1'b0;
    end
  end

  assign memValid = busy;
  assign pendBits = pend;
endmodule

// File: rtl/intr_deliver.sv
module intr_deliver #(
  parameter int NumVec   = 5,
  parameter int NumWired = 4,
  parameter int ReqW     = 3,
  parameter int AddrW    = 12,
  parameter logic [AddrW-1:0] MsgBase = 12'h300
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ReqW-1:0]     reqVector,
  input  logic                regWrEn,
  input  logic [AddrW-1:0]    regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic [NumWired-1:0] wiredIrq,
  output logic                memValid,
  input  logic                memReady,
  output logic [63:0]         memAddr,
  output logic [31:0]         memData
);
  intr_pkg::ctrlStrobes_t strobes;
  logic [ReqW-1:0]   issueVec;
  logic [NumVec-1:0] pendBits;
  logic wiredMode, errFlag;

  intr_ctrl #(.NumVec(NumVec), .NumWired(NumWired), .ReqW(ReqW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .wiredMode(wiredMode), .memReady(memReady), .memValid(memValid),
    .wiredIrq(wiredIrq), .pendBits(pendBits), .strobes(strobes),
    .issueVec(issueVec)
  );

  intr_regs #(.NumVec(NumVec), .ReqW(ReqW), .AddrW(AddrW), .MsgBase(MsgBase)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .issueVec(issueVec), .pendBits(pendBits), .wiredMode(wiredMode),
    .errFlag(errFlag), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/intr_deliver_chk.sv
module intr_deliver_chk #(
  parameter int NumVec   = 5,
  parameter int NumWired = 4,
  parameter int ReqW     = 3,
  parameter int AddrW    = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [ReqW-1:0]     reqVector,
  input logic                regWrEn,
  input logic [AddrW-1:0]    regAddr,
  input logic [31:0]         regWrData,
  input logic [NumWired-1:0] wiredIrq,
  input logic                memValid,
  input logic                memReady,
  input logic [63:0]         memAddr,
  input logic [31:0]         memData,
  input logic                errFlag
);
  localparam logic [ReqW-1:0]  MsgLim  = ReqW'(NumVec);
  localparam logic [AddrW-1:0] StatOff = AddrW'(4);

  AST_WIRED_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wiredIrq)); // R2

  AST_WIRED_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (|wiredIrq) |-> $past(reqValid)); // R2

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(regWrEn && regAddr == StatOff && regWrData[0])) |=> errFlag); // R7

  AST_OOR_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVector >= MsgLim) |=> (wiredIrq == '0)); // R7
endmodule

bind intr_deliver intr_deliver_chk #(
  .NumVec(NumVec), .NumWired(NumWired), .ReqW(ReqW), .AddrW(AddrW)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .wiredIrq(wiredIrq), .memValid(memValid), .memReady(memReady),
  .memAddr(memAddr), .memData(memData), .errFlag(errFlag)
);

// File: tb/tb_intr_deliver.sv
`timescale 1ns/1ps
module tb_intr_deliver;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqVector = '0;
  logic regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0] wiredIrq;
  logic memValid;
  logic memReady = 1'b0;
  logic [63:0] memAddr;
  logic [31:0] memData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  intr_deliver dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .wiredIrq(wiredIrq), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [31:0] addrLo(int e); return 32'h8000_0000 | (e << 8); endfunction
  function automatic logic [31:0] addrHi(int e); return 32'h0000_0010 + e; endfunction
  function automatic logic [31:0] dataW(int e);  return 32'hCAFE_0000 + e * 17; endfunction
  function automatic logic [31:0] spareW(int e); return 32'h5A5A_0000 + e; endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendReq(logic [2:0] v);
    @(negedge clk);
    reqValid = 1'b1; reqVector = v;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic takeMsg(int e, string tag);
    int waited = 0;
    while (!memValid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " valid"}, 64'(memValid), 64'd1);
    check({tag, " addr"}, memAddr, {addrHi(e), addrLo(e)});
    check({tag, " data"}, 64'(memData), 64'(dataW(e)));
    @(negedge clk);
    check({tag, " held"}, {memValid, memAddr[62:0]}, {1'b1, addrHi(e)[30:0], addrLo(e)});
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int w = 0; w < 20; w++) begin
      regRead(12'h300 + 12'(4 * w), rd);
      check("R1 table word", 64'(rd), 64'd0);
    end
    regRead(12'h000, rd); check("R1 ctrl", 64'(rd), 64'd0);
    regRead(12'h004, rd); check("R1 status", 64'(rd), 64'd0);
    regRead(12'h400, rd); check("R1 pending lo", 64'(rd), 64'd0);
    regRead(12'h404, rd); check("R1 pending hi", 64'(rd), 64'd0);
    check("R1 outputs", {59'd0, memValid, wiredIrq}, 64'd0);

    // R6: program table, read back both halves of each address
    for (int e = 0; e < 5; e++) begin
      regWrite(12'h300 + 12'(16 * e),     addrLo(e));
      regWrite(12'h300 + 12'(16 * e + 4), addrHi(e));
      regWrite(12'h300 + 12'(16 * e + 8), dataW(e));
      regWrite(12'h300 + 12'(16 * e + 12), spareW(e));
    end
    for (int e = 0; e < 5; e++) begin
      regRead(12'h300 + 12'(16 * e),     rd); check("R6 addr low", 64'(rd), 64'(addrLo(e)));
      regRead(12'h300 + 12'(16 * e + 4), rd); check("R6 addr high", 64'(rd), 64'(addrHi(e)));
      regRead(12'h300 + 12'(16 * e + 8), rd); check("R6 data", 64'(rd), 64'(dataW(e)));
      regRead(12'h300 + 12'(16 * e + 12), rd); check("R6 spare", 64'(rd), 64'(spareW(e)));
    end

    // R8 and R2: wired mode sweep
    regWrite(12'h000, 32'h1);
    regRead(12'h000, rd); check("R8 ctrl readback", 64'(rd), 64'd1);
    for (int v = 0; v < 4; v++) begin
      sendReq(3'(v));
      check("R2 pulse", 64'(wiredIrq), 64'(1 << v));
      @(negedge clk);
      check("R2 pulse ends", 64'(wiredIrq), 64'd0);
      check("R2 no message", 64'(memValid), 64'd0);
    end

    // R7: out-of-range in wired mode
    for (int v = 4; v < 8; v++) begin
      sendReq(3'(v));
      check("R7 wired oor no pulse", 64'(wiredIrq), 64'd0);
      regRead(12'h004, rd); check("R7 error set", 64'(rd), 64'd1);
      regWrite(12'h004, 32'h1);
      regRead(12'h004, rd); check("R7 error cleared", 64'(rd), 64'd0);
    end

    // R3: message mode sweep
    regWrite(12'h000, 32'h0);
    for (int v = 0; v < 5; v++) begin
      sendReq(3'(v));
      check("R3 no wired pulse", 64'(wiredIrq), 64'd0);
      takeMsg(v, "R3 message");
      @(negedge clk);
      check("R3 write done", 64'(memValid), 64'd0);
    end
    regRead(12'h004, rd); check("R7 no error for in-range", 64'(rd), 64'd0);

    // R7: out-of-range in message mode, flag sticky
    for (int v = 5; v < 8; v++) begin
      sendReq(3'(v));
      repeat (3) @(negedge clk);
      check("R7 msg oor no write", {62'd0, memValid, |wiredIrq}, 64'd0);
    end
    regWrite(12'h004, 32'h0);
    regRead(12'h004, rd); check("R7 sticky after write 0", 64'(rd), 64'd1);
    regWrite(12'h004, 32'h1);
    regRead(12'h004, rd); check("R7 cleared", 64'(rd), 64'd0);

    // R4 and R5: queued requests, lowest first
    sendReq(3'd1);
    sendReq(3'd4);
    sendReq(3'd2);
    sendReq(3'd3);
    regRead(12'h400, rd); check("R5 pending bits", 64'(rd), 64'h1C);
    regWrite(12'h400, 32'h0);
    regRead(12'h400, rd); check("R5 write ignored", 64'(rd), 64'h1C);
    regWrite(12'h404, 32'hFFFF_FFFF);
    regRead(12'h404, rd); check("R5 upper word zero", 64'(rd), 64'd0);
    takeMsg(1, "R4 first");
    takeMsg(2, "R4 second");
    takeMsg(3, "R4 third");
    takeMsg(4, "R4 fourth");
    regRead(12'h400, rd); check("R5 pending drained", 64'(rd), 64'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule